// File: doc/BRIEF.md
# Memory Region Scoreboard

This block keeps track of memory-to-memory operations that have been handed to an attached reconfigurable compute unit and have not yet finished. Every such operation names two memory blocks: one it reads and one it writes. Each block is given as a base address and a size code `lg`, and the size is 2^lg bytes. Because the block is naturally aligned, the low `lg` bits of the base are ignored. With this record in place, the processor and the unit can run at the same time, while the program still sees memory as if every operation and every processor access had run one after another in program order.

Three kinds of request are checked against the table of pending operations: processor loads, processor stores and new dispatches. A request that could observe or disturb a region still in use is stalled. A dispatch that is accepted takes the lowest-numbered free entry, and its index is returned to the caller. When the unit finishes, it reports that index. The entry is released in the same cycle, so a request that conflicted only with that entry is allowed through in that cycle. Several operations can be pending at once, which covers several units running in parallel. Each new dispatch is checked against all of them.

Top module: `mem_region_sb`

## Requirements
- R1: After reset no entry is pending. Loads and stores do not stall, and a dispatch is accepted with `disp_idx_o` = 0.
- R2: An accepted dispatch occupies the lowest-numbered free entry, reported on `disp_idx_o` in the accept cycle. The entry is pending from the next cycle.
- R3: When all NUM_ENTRIES entries are pending and none completes, a valid dispatch stalls even without any region conflict.
- R4: A load stalls when its address lies inside the destination region of a pending entry. An address inside only a pending source region, or one byte past a destination region, does not stall.
- R5: A store stalls when its address lies inside the source region or the destination region of any pending entry.
- R6: A dispatch stalls when its destination region overlaps the source region or the destination region of any pending entry.
- R7: A dispatch stalls when its source region overlaps the destination region of a pending entry. A source that overlaps only pending source regions is accepted.
- R8: A region with size code lg covers the aligned 2^lg-byte block that holds its base, so the base's low lg bits are ignored. Two regions overlap when their addresses agree above the larger of the two size codes.
- R9: While `cmpl_valid_i` is high, the entry `cmpl_idx_i` no longer causes any stall in that cycle. It may be reallocated in that same cycle, and it is free from the next cycle.
- R10: A completion naming an entry that is not pending changes nothing. A stalled dispatch allocates nothing.
- R11: `disp_accept_o` and `disp_stall_o` are never both high. Exactly one of them is high while `disp_valid_i` is high. No stall output is high while its valid input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | New operation offered |
| disp_src_base_i | input | ADDR_W | Source region base address |
| disp_src_lg_i | input | LG_W | Source region size code (2^lg bytes) |
| disp_dst_base_i | input | ADDR_W | Destination region base address |
| disp_dst_lg_i | input | LG_W | Destination region size code |
| disp_accept_o | output | 1 | Operation accepted this cycle |
| disp_stall_o | output | 1 | Operation must wait |
| disp_idx_o | output | IDX_W | Entry index given to the accepted operation |
| ld_valid_i | input | 1 | Processor load present |
| ld_addr_i | input | ADDR_W | Load address |
| ld_stall_o | output | 1 | Load must wait |
| st_valid_i | input | 1 | Processor store present |
| st_addr_i | input | ADDR_W | Store address |
| st_stall_o | output | 1 | Store must wait |
| cmpl_valid_i | input | 1 | Unit reports an operation finished |
| cmpl_idx_i | input | IDX_W | Index of the finished entry |

## Verification
The main risk is an entry whose valid bit or stored region is wrong. If an entry is lost, a load or store that should wait goes through at once, in the same cycle it is presented. If an entry is stuck, a stall never clears, and the next dispatch gets a higher index than expected in its accept cycle. A bad mask or size comparison shows up at the edges of a region, so the bench probes the last byte inside a region, the first byte past it, and a large region that contains a small one. The same-cycle release after a completion is checked in the completion cycle itself, before any clock edge.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int ADDR_W = 32;
  localparam int LG_W   = 6;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LG_W-1:0]   lg;
  } region_t;

  // aligned power-of-two blocks overlap when equal above the larger size
  function automatic logic region_overlap(region_t a, region_t b);
    logic [LG_W-1:0]   mx;
    logic [ADDR_W-1:0] msk;
    mx  = (a.lg > b.lg) ? a.lg : b.lg;
    msk = {ADDR_W{1'b1}} << mx;
    return ((a.base ^ b.base) & msk) == '0;
  endfunction
endpackage

// File: rtl/sb_entry_store.sv
module sb_entry_store
  import sb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         alloc_en_i,
  input  logic [IDX_W-1:0]             alloc_idx_i,
  input  region_t                      alloc_src_i,
  input  region_t                      alloc_dst_i,
  input  logic [NUM_ENTRIES-1:0]       free_i,
  output logic [NUM_ENTRIES-1:0]       valid_o,
  output region_t [NUM_ENTRIES-1:0]    src_o,
  output region_t [NUM_ENTRIES-1:0]    dst_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic hit;
    assign hit = alloc_en_i && (alloc_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        src_o[g]   <= '0;
        dst_o[g]   <= '0;
      end else if (hit) begin
        valid_o[g] <= 1'b1;
        src_o[g]   <= alloc_src_i;
        dst_o[g]   <= alloc_dst_i;
      end else if (free_i[g]) begin
        valid_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sb_conflict.sv
module sb_conflict
  import sb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic [NUM_ENTRIES-1:0]    live_i,
  input  region_t [NUM_ENTRIES-1:0] src_i,
  input  region_t [NUM_ENTRIES-1:0] dst_i,
  input  logic [ADDR_W-1:0]         ld_addr_i,
  input  logic [ADDR_W-1:0]         st_addr_i,
  input  region_t                   new_src_i,
  input  region_t                   new_dst_i,
  output logic                      ld_hit_o,
  output logic                      st_hit_o,
  output logic                      disp_hit_o
);
  logic [NUM_ENTRIES-1:0] ld_v, st_v, dp_v;
  region_t ld_pt, st_pt;
  assign ld_pt = '{base: ld_addr_i, lg: '0};
  assign st_pt = '{base: st_addr_i, lg: '0};

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    logic ld_d, st_s, st_d, nd_s, nd_d, ns_d;
    assign ld_d = region_overlap(ld_pt, dst_i[g]);
    assign st_s = region_overlap(st_pt, src_i[g]);
    assign st_d = region_overlap(st_pt, dst_i[g]);
    assign nd_s = region_overlap(new_dst_i, src_i[g]);
    assign nd_d = region_overlap(new_dst_i, dst_i[g]);
    assign ns_d = region_overlap(new_src_i, dst_i[g]);
    assign ld_v[g] = live_i[g] && ld_d;
    assign st_v[g] = live_i[g] && (st_s || st_d);
    assign dp_v[g] = live_i[g] && (nd_s || nd_d || ns_d);
  end

  assign ld_hit_o   = |ld_v;
  assign st_hit_o   = |st_v;
  assign disp_hit_o = |dp_v;
endmodule

// File: rtl/sb_alloc.sv
module sb_alloc #(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0] avail_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o
);
  always_comb begin
    any_o = |avail_i;
    idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (avail_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mem_region_sb.sv
module mem_region_sb
  import sb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [ADDR_W-1:0] disp_src_base_i,
  input  logic [LG_W-1:0]   disp_src_lg_i,
  input  logic [ADDR_W-1:0] disp_dst_base_i,
  input  logic [LG_W-1:0]   disp_dst_lg_i,
  output logic              disp_accept_o,
  output logic              disp_stall_o,
  output logic [IDX_W-1:0]  disp_idx_o,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              ld_stall_o,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              st_stall_o,
  input  logic              cmpl_valid_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i
);
  logic [NUM_ENTRIES-1:0]    valid_q, free_vec, live;
  region_t [NUM_ENTRIES-1:0] src_q, dst_q;
  region_t                   new_src, new_dst;
  logic                      ld_hit, st_hit, disp_hit, any_free;
  logic [IDX_W-1:0]          free_idx;

  assign new_src = '{base: disp_src_base_i, lg: disp_src_lg_i};
  assign new_dst = '{base: disp_dst_base_i, lg: disp_dst_lg_i};

  // completion releases its entry for this cycle's checks
  assign free_vec = cmpl_valid_i ? (NUM_ENTRIES'(1) << cmpl_idx_i) : '0;
  assign live     = valid_q & ~free_vec;

  sb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_en_i  (disp_accept_o),
    .alloc_idx_i (free_idx),
    .alloc_src_i (new_src),
    .alloc_dst_i (new_dst),
    .free_i      (free_vec),
    .valid_o     (valid_q),
    .src_o       (src_q),
    .dst_o       (dst_q)
  );

  sb_conflict #(.NUM_ENTRIES(NUM_ENTRIES)) u_conf (
    .live_i     (live),
    .src_i      (src_q),
    .dst_i      (dst_q),
    .ld_addr_i  (ld_addr_i),
    .st_addr_i  (st_addr_i),
    .new_src_i  (new_src),
    .new_dst_i  (new_dst),
    .ld_hit_o   (ld_hit),
    .st_hit_o   (st_hit),
    .disp_hit_o (disp_hit)
  );

  sb_alloc #(.NUM_ENTRIES(NUM_ENTRIES)) u_alloc (
    .avail_i (~live),
    .any_o   (any_free),
    .idx_o   (free_idx)
  );

  assign disp_stall_o  = disp_valid_i && (disp_hit || !any_free);
  assign disp_accept_o = disp_valid_i && !disp_hit && any_free;
  assign disp_idx_o    = free_idx;
  assign ld_stall_o    = ld_valid_i && ld_hit;
  assign st_stall_o    = st_valid_i && st_hit;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disp_valid_i,
  input logic             disp_accept_o,
  input logic             disp_stall_o,
  input logic [IDX_W-1:0] disp_idx_o,
  input logic             ld_valid_i,
  input logic             ld_stall_o,
  input logic             st_valid_i,
  input logic             st_stall_o,
  input logic             cmpl_valid_i,
  input logic [IDX_W-1:0] cmpl_idx_i
);
  // occupancy rebuilt from port traffic only
  logic [NUM_ENTRIES-1:0] pend_q, pend_d;
  always_comb begin
    pend_d = pend_q;
    if (cmpl_valid_i) pend_d[cmpl_idx_i] = 1'b0;
    if (disp_accept_o) pend_d[disp_idx_o] = 1'b1;
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assert_empty_free_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |-> (!ld_stall_o && !st_stall_o && (!disp_valid_i || disp_accept_o)));

  assert_alloc_free_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_accept_o |-> (!pend_q[disp_idx_o] || (cmpl_valid_i && cmpl_idx_i == disp_idx_o)));

  assert_full_stalls_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pend_q && disp_valid_i && !cmpl_valid_i) |-> disp_stall_o);

  assert_disp_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i == (disp_accept_o ^ disp_stall_o));

  assert_quiet_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_valid_i |-> !ld_stall_o) and (!st_valid_i |-> !st_stall_o));
endmodule

bind mem_region_sb sb_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (.*);

// File: tb/sim_mem_region_sb.sv
module sim_mem_region_sb;
  localparam int AW = 32;
  localparam int LW = 6;
  localparam int IW = 2;

  logic clk_i = 0, rst_ni = 0;
  logic disp_valid_i = 0;
  logic [AW-1:0] disp_src_base_i = 0, disp_dst_base_i = 0;
  logic [LW-1:0] disp_src_lg_i = 0, disp_dst_lg_i = 0;
  logic disp_accept_o, disp_stall_o;
  logic [IW-1:0] disp_idx_o;
  logic ld_valid_i = 0, st_valid_i = 0;
  logic [AW-1:0] ld_addr_i = 0, st_addr_i = 0;
  logic ld_stall_o, st_stall_o;
  logic cmpl_valid_i = 0;
  logic [IW-1:0] cmpl_idx_i = 0;

  int n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  mem_region_sb u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // offer a dispatch, check outcome, let one edge pass
  task automatic disp(input logic [AW-1:0] sb, input logic [LW-1:0] sl,
                      input logic [AW-1:0] db, input logic [LW-1:0] dl,
                      input logic acc, input logic [IW-1:0] idx, input string req);
    @(negedge clk_i);
    disp_valid_i = 1; disp_src_base_i = sb; disp_src_lg_i = sl;
    disp_dst_base_i = db; disp_dst_lg_i = dl;
    #1;
    chk(req, {7'd0, disp_accept_o}, {7'd0, acc});
    chk(req, {7'd0, disp_stall_o}, {7'd0, !acc});
    if (acc) chk(req, {6'd0, disp_idx_o}, {6'd0, idx});
    @(posedge clk_i); #1;
    disp_valid_i = 0;
  endtask

  task automatic probe_ld(input logic [AW-1:0] a, input logic exp, input string req);
    @(negedge clk_i);
    ld_valid_i = 1; ld_addr_i = a; #1;
    chk(req, {7'd0, ld_stall_o}, {7'd0, exp});
    ld_valid_i = 0;
  endtask

  task automatic probe_st(input logic [AW-1:0] a, input logic exp, input string req);
    @(negedge clk_i);
    st_valid_i = 1; st_addr_i = a; #1;
    chk(req, {7'd0, st_stall_o}, {7'd0, exp});
    st_valid_i = 0;
  endtask

  task automatic complete(input logic [IW-1:0] idx);
    @(negedge clk_i);
    cmpl_valid_i = 1; cmpl_idx_i = idx;
    @(posedge clk_i); #1;
    cmpl_valid_i = 0;
  endtask

  task automatic t_reset;
    probe_ld(32'h2080, 0, "R1 load after reset");
    probe_st(32'h1040, 0, "R1 store after reset");
    disp(32'h1000, 8, 32'h2000, 8, 1, 0, "R1 first dispatch idx0");
  endtask

  task automatic t_proc_access;
    probe_ld(32'h2080, 1, "R4 load in dst");
    probe_ld(32'h20FF, 1, "R4 load last dst byte");
    probe_ld(32'h2100, 0, "R4 load past dst");
    probe_ld(32'h1080, 0, "R4 load in src only");
    probe_st(32'h1040, 1, "R5 store in src");
    probe_st(32'h20FF, 1, "R5 store in dst");
    probe_st(32'h3000, 0, "R5 store clear");
  endtask

  task automatic t_disp_rules;
    disp(32'h5000, 4, 32'h1000, 4, 0, 0, "R6 dst over pending src");
    disp(32'h5000, 4, 32'h2040, 4, 0, 0, "R6 dst over pending dst");
    disp(32'h2010, 4, 32'h6000, 4, 0, 0, "R7 src over pending dst");
    disp(32'h1010, 4, 32'h7000, 4, 1, 1, "R7 src-src ok, R10 no alloc on stall, R2 idx1");
    probe_st(32'h7008, 1, "R2 entry pending next cycle");
  endtask

  task automatic t_sizes;
    disp(32'hF0000, 4, 32'h0000, 16, 0, 0, "R8 large dst holds small regions");
    disp(32'h8000, 4, 32'h30F7, 8, 1, 2, "R8 unaligned base idx2");
    probe_ld(32'h3001, 1, "R8 base low bits ignored");
    probe_ld(32'h3100, 0, "R8 end of aligned block");
    disp(32'h9000, 2, 32'hA000, 2, 1, 3, "R2 idx3");
    probe_ld(32'hA004, 0, "R8 size code 2 is four bytes");
    disp(32'hB000, 4, 32'hC000, 4, 0, 0, "R3 full stalls");
  endtask

  task automatic t_release;
    // completion and dispatch in the same cycle
    @(negedge clk_i);
    cmpl_valid_i = 1; cmpl_idx_i = 1;
    disp_valid_i = 1; disp_src_base_i = 32'hB000; disp_src_lg_i = 4;
    disp_dst_base_i = 32'hC000; disp_dst_lg_i = 4; #1;
    chk("R9 reuse in completion cycle", {7'd0, disp_accept_o}, 8'd1);
    chk("R9 reuse idx", {6'd0, disp_idx_o}, 8'd1);
    @(posedge clk_i); #1;
    cmpl_valid_i = 0; disp_valid_i = 0;
    // conflict released within the completion cycle
    @(negedge clk_i);
    cmpl_valid_i = 1; cmpl_idx_i = 0; ld_valid_i = 1; ld_addr_i = 32'h2080; #1;
    chk("R9 load released same cycle", {7'd0, ld_stall_o}, 8'd0);
    cmpl_valid_i = 0; #1;
    chk("R9 entry held without completion", {7'd0, ld_stall_o}, 8'd1);
    ld_valid_i = 0;
    complete(0);
    probe_ld(32'h2080, 0, "R9 entry freed");
  endtask

  task automatic t_idle_cmpl;
    complete(0);
    probe_ld(32'h3001, 1, "R10 stray completion keeps entry2");
    probe_st(32'hB008, 1, "R10 stray completion keeps entry1");
    disp(32'hD000, 4, 32'hE000, 4, 1, 0, "R2 lowest free idx0");
  endtask

  task automatic t_quiet;
    @(negedge clk_i);
    ld_addr_i = 32'h3001; st_addr_i = 32'h3001;
    disp_dst_base_i = 32'h3000; disp_dst_lg_i = 4; #1;
    chk("R11 ld stall needs valid", {7'd0, ld_stall_o}, 8'd0);
    chk("R11 st stall needs valid", {7'd0, st_stall_o}, 8'd0);
    chk("R11 disp stall needs valid", {7'd0, disp_stall_o}, 8'd0);
    chk("R11 no accept without valid", {7'd0, disp_accept_o}, 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    t_reset;
    t_proc_access;
    t_disp_rules;
    t_sizes;
    t_release;
    t_idle_cmpl;
    t_quiet;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule